// File: doc/BRIEF.md
# Audio Serial Port Interrupt Register Bank

This block gathers the interrupt sources of a multi-channel audio serial port and drives one interrupt line. Per-channel events from the datapath and a few FIFO and framing events land in two status words. Software picks which of them may raise the line by writing two mask words. The block sits behind a plain 32-bit word-addressed register port with separate write and read strobes. The datapath drives the event inputs directly.

Each group has four word slots. A write-one-to-set word and a write-one-to-clear word change the mask, and two read-only words expose the mask and the status. Group A packs its per-channel events into byte lanes by event type. Group B carries the word error and the FIFO level flags.

Ready and FIFO-level flags mirror their live inputs. Underrun, overflow and word-error flags are sticky: they are set by a one-cycle strobe and cleared by reading their status word.

Top module: `audio_irq_bank`

## Requirements
- R1: After reset both mask words read 0, all sticky status bits read 0, and `irq` is low.
- R2: A write to word 0 (group A) or word 4 (group B) sets every mask bit whose `wdata` bit is 1. Mask bits whose `wdata` bit is 0 keep their value.
- R3: A write to word 1 (group A) or word 5 (group B) clears every mask bit whose `wdata` bit is 1. Mask bits whose `wdata` bit is 0 keep their value.
- R4: Reading word 3 (group A status) returns the channel k transmit-ready input at bit k and the channel k receive-ready input at bit 16+k. Both follow the live inputs.
- R5: A strobe on channel k's transmit-underrun input sets bit 8+k of word 3. A strobe on channel k's receive-overflow input sets bit 24+k. Each such bit stays set until word 3 is read.
- R6: Reading word 7 (group B status) returns the sticky word error at bit 0, transmit FIFO ready at bit 8, transmit FIFO empty at bit 9, receive FIFO ready at bit 12 and receive FIFO full at bit 13. All other bits read 0.
- R7: A read of word 3 clears the group A sticky bits, and a read of word 7 clears the word-error bit. The clear takes effect at the clock edge of the read. The read itself returns the value held before the clear.
- R8: A strobe arriving in the same cycle as a clearing read of its status word leaves that status bit set.
- R9: `irq` is high exactly when (mask AND status) is non-zero in group A or in group B.
- R10: Writes to the mask and status words (2, 3, 6, 7) change no state. Words 0, 1, 4 and 5 read as 0.
- R11: Only bits 0, 8, 9, 12 and 13 of the group B mask can be set. Only bits that belong to the configured channels can be set in the group A mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears sticky bits on status reads) |
| addr | input | 3 | Word index 0..7 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tx_ready | input | NCH | Per-channel transmit-ready level |
| tx_underrun | input | NCH | Per-channel transmit-underrun strobe |
| rx_ready | input | NCH | Per-channel receive-ready level |
| rx_overflow | input | NCH | Per-channel receive-overflow strobe |
| word_err | input | 1 | Word error strobe |
| txf_ready | input | 1 | Transmit FIFO ready level |
| txf_empty | input | 1 | Transmit FIFO empty level |
| rxf_ready | input | 1 | Receive FIFO ready level |
| rxf_full | input | 1 | Receive FIFO full level |
| irq | output | 1 | Interrupt request |

## Verification
A corrupt mask bit shows up at the next read of the mask word. It also shows on `irq` in the same cycle, because the line is a combinational function of the mask and status state. A lost or stuck sticky bit is visible on the first status read after the strobe, and it shows again on the read after that, which must return zero. Interplay between clear and set is exposed by a strobe placed in the very cycle of a clearing read, followed by a second read one cycle later.

// File: rtl/audio_irq_bank.sv
module audio_irq_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic [NCH-1:0] tx_ready,
  input  logic [NCH-1:0] tx_underrun,
  input  logic [NCH-1:0] rx_ready,
  input  logic [NCH-1:0] rx_overflow,
  input  logic           word_err,
  input  logic           txf_ready,
  input  logic           txf_empty,
  input  logic           rxf_ready,
  input  logic           rxf_full,
  output logic           irq
);

  localparam logic [7:0]  CHM     = 8'((1 << NCH) - 1);
  localparam logic [31:0] A_VALID = {CHM, CHM, CHM, CHM};
  localparam int          B_WERR  = 0;
  localparam int          B_TXFR  = 8;
  localparam int          B_TXFE  = 9;
  localparam int          B_RXFR  = 12;
  localparam int          B_RXFF  = 13;
  localparam logic [31:0] B_VALID = (32'd1 << B_WERR) | (32'd1 << B_TXFR) |
                                    (32'd1 << B_TXFE) | (32'd1 << B_RXFR) |
                                    (32'd1 << B_RXFF);

  logic [31:0] mask_a, mask_b;
  logic [7:0]  unf_q, ovf_q;
  logic        werr_q;
  logic [31:0] stat_a, stat_b;
  logic        clr_a, clr_b;
  logic [7:0]  txr8, rxr8, unf8, ovf8;

  assign txr8 = 8'(tx_ready) & CHM;
  assign rxr8 = 8'(rx_ready) & CHM;
  assign unf8 = 8'(tx_underrun) & CHM;
  assign ovf8 = 8'(rx_overflow) & CHM;

  assign clr_a = rd_en && (addr == 3'd3);
  assign clr_b = rd_en && (addr == 3'd7);

  assign stat_a = {ovf_q, rxr8, unf_q, txr8};

  always_comb begin
    stat_b = '0;
    stat_b[B_WERR] = werr_q;
    stat_b[B_TXFR] = txf_ready;
    stat_b[B_TXFE] = txf_empty;
    stat_b[B_RXFR] = rxf_ready;
    stat_b[B_RXFF] = rxf_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_a <= '0;
      mask_b <= '0;
      unf_q  <= '0;
      ovf_q  <= '0;
      werr_q <= 1'b0;
    end else begin
      unf_q  <= (clr_a ? 8'h00 : unf_q) | unf8;
      ovf_q  <= (clr_a ? 8'h00 : ovf_q) | ovf8;
      werr_q <= (clr_b ? 1'b0 : werr_q) | word_err;
      if (wr_en) begin
        case (addr)
          3'd0:    mask_a <= mask_a | (wdata & A_VALID);
          3'd1:    mask_a <= mask_a & ~wdata;
          3'd4:    mask_b <= mask_b | (wdata & B_VALID);
          3'd5:    mask_b <= mask_b & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd2:    rdata = mask_a;
      3'd3:    rdata = stat_a;
      3'd6:    rdata = mask_b;
      3'd7:    rdata = stat_b;
      default: rdata = '0;
    endcase
  end

  assign irq = (|(mask_a & stat_a)) | (|(mask_b & stat_b));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> ((mask_a & $past(wdata & A_VALID)) == $past(wdata & A_VALID)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> ((mask_a & $past(wdata)) == 32'd0));

  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_a |=> ((unf_q & $past(unf_q)) == $past(unf_q)));

  p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|unf8) |=> ((unf_q & $past(unf8)) == $past(unf8)));

  p_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 3'd0 || addr == 3'd1)) |=> $stable(mask_a));

  p_mask_b_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_b & ~B_VALID) == 32'd0);

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|mask_a) || (|mask_b)));

endmodule

// File: tb/audio_irq_bank_test.sv
module audio_irq_bank_test;
  localparam int CLK_P = 10;
  localparam int NCH = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NCH-1:0] tx_ready = 0, tx_underrun = 0, rx_ready = 0, rx_overflow = 0;
  logic word_err = 0, txf_ready = 0, txf_empty = 0, rxf_ready = 0, rxf_full = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_irq_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_ready(rx_ready), .rx_overflow(rx_overflow), .word_err(word_err),
    .txf_ready(txf_ready), .txf_empty(txf_empty), .rxf_ready(rxf_ready),
    .rxf_full(rxf_full), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_events(input logic [NCH-1:0] unf, input logic [NCH-1:0] ovf, input logic we);
    @(negedge clk); tx_underrun = unf; rx_overflow = ovf; word_err = we;
    @(negedge clk); tx_underrun = 0; rx_overflow = 0; word_err = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd2, d); check("R1 mask A", d, 0);
    rd(3'd6, d); check("R1 mask B", d, 0);
    rd(3'd3, d); check("R1 status A", d, 0);
    rd(3'd7, d); check("R1 status B", d, 0);
    #1 check("R1 irq", irq, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(3'd0, 32'h0000_00F0); rd(3'd2, d); check("R2 set", d, 32'h0000_00F0);
    wr(3'd0, 32'h0000_000F); rd(3'd2, d); check("R2 zero bits keep", d, 32'h0000_00FF);
    wr(3'd1, 32'h0000_0030); rd(3'd2, d); check("R3 clear", d, 32'h0000_00CF);
    wr(3'd1, 32'h0); rd(3'd2, d); check("R3 zero bits keep", d, 32'h0000_00CF);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd2, d); check("R3 clear all", d, 0);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd6, d); check("R11 B legal bits", d, 32'h0000_3301);
    wr(3'd5, 32'h0000_0100); rd(3'd6, d); check("R3 B clear", d, 32'h0000_3201);
    wr(3'd5, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    tx_ready = 8'hA5; rx_ready = 8'h3C;
    rd(3'd3, d); check("R4 level", d, 32'h003C_00A5);
    tx_ready = 8'h01; rx_ready = 8'h80;
    rd(3'd3, d); check("R4 follow", d, 32'h0080_0001);
    tx_ready = 0; rx_ready = 0;
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse_events(8'h02, 8'h80, 1'b0);
    repeat (3) @(negedge clk);
    rd(3'd3, d); check("R5 sticky held", d, 32'h8000_0200);
    rd(3'd3, d); check("R7 cleared by read", d, 0);
  endtask

  task automatic t_group_b();
    logic [31:0] d;
    txf_ready = 1; rxf_full = 1;
    pulse_events(0, 0, 1'b1);
    rd(3'd7, d); check("R6 layout", d, 32'h0000_2101);
    rd(3'd7, d); check("R7 B clears werr only", d, 32'h0000_2100);
    txf_ready = 0; rxf_full = 0; txf_empty = 1; rxf_ready = 1;
    rd(3'd7, d); check("R6 other flags", d, 32'h0000_1200);
    txf_empty = 0; rxf_ready = 0;
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk); rd_en = 1; addr = 3'd3; tx_underrun = 8'h01;
    #1 check("R7 read returns pre-clear", rdata, 0);
    @(negedge clk); rd_en = 0; tx_underrun = 0;
    rd(3'd3, d); check("R8 strobe survives clear", d, 32'h0000_0100);
    rd(3'd3, d); check("R7 then clears", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    tx_ready = 8'h08; #1 check("R9 unmasked no irq", irq, 0);
    wr(3'd0, 32'h0000_0008); #1 check("R9 irq tx ready", irq, 1);
    tx_ready = 0; #1 check("R9 irq drops", irq, 0);
    wr(3'd1, 32'h0000_0008);
    wr(3'd4, 32'h0000_2000); rxf_full = 1; #1 check("R9 irq group B", irq, 1);
    rxf_full = 0; wr(3'd5, 32'h0000_2000);
    wr(3'd0, 32'h0100_0000);
    pulse_events(0, 8'h01, 1'b0); #1 check("R9 irq sticky", irq, 1);
    rd(3'd3, d); #1 check("R9 irq cleared by read", irq, 0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(3'd0, 32'h0000_0055);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R10 mask word write ignored", d, 32'h0000_0055);
    pulse_events(8'h04, 0, 1'b0);
    wr(3'd3, 32'h0); rd(3'd3, d); check("R10 status write ignored", d, 32'h0000_0400);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); check("R10 mask B write ignored", d, 0);
    rd(3'd0, d); check("R10 word 0 reads 0", d, 0);
    rd(3'd5, d); check("R10 word 5 reads 0", d, 0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_set_clear();
    t_level();
    t_sticky();
    t_group_b();
    t_collision();
    t_irq();
    t_readonly();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule